// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between a bus request queue and the per-area access engines of an external memory controller. The controller has four address areas. Areas 0 and 3 are static-memory style and areas 1 and 2 are SDRAM style. The block remembers the area and direction of the last access it issued. It then holds each new request back until enough idle bus cycles have passed since the engine finished that access. The number of idle cycles required depends on the pair of area classes, on whether the area changes, and on the read/write direction of both accesses. Some of these gaps come from 4-bit configuration inputs. Others are fixed floors, and where a floor applies the block uses the larger of the floor and the programmed value.

Requests arrive on a valid/ready handshake. Each request carries an area, a write flag and a size code. The block sends each access to the engines as a one-cycle issue strobe. The engine answers with a one-cycle done pulse when the access has finished on the bus. A wide transfer to a static area is broken into 4-byte beats, and the idle gap is applied before every beat. A wide transfer to an SDRAM area is passed on as one access with its size code unchanged.

The gap g is counted as follows. g idle cycles lie strictly between the cycle of the done pulse and the issue cycle. If the request is already waiting, it issues g+1 cycles after the done cycle.

Top module: `idle_gap_issuer`

## Requirements
- R1: After reset there is no previous access. req_ready_o is high, and the first valid request is issued in the same cycle it is presented, with no idle gap.
- R2: A request is taken when req_valid_i and req_ready_o are both high. In that cycle iss_valid_o pulses for one cycle with iss_area_o and iss_wr_o (1 = write) equal to the request. No further issue happens until eng_done_i has been seen in a cycle after the issue cycle.
- R3: Let g be the required gap. The next access issues no earlier than g+1 cycles after the done cycle, and exactly then if it is already waiting.
- R4: Static to static. The gap is taken from cfg_same_i when both accesses use the same area and from cfg_diff_i otherwise. The 4-bit field is selected by {previous is write, next is write}: bits [3:0] read→read, [7:4] read→write, [11:8] write→read, [15:12] write→write.
- R5: Static (0 or 3) followed by SDRAM (1 or 2). The gap is the larger of 4 and the cfg_diff_i field chosen as in R4.
- R6: SDRAM followed by the same SDRAM area in the same direction. The gap is 1.
- R7: SDRAM followed by the same SDRAM area. For write then read, the gap is the larger of cfg_w2r_i and 1. For read then write, it is the larger of cfg_r2w_i and 1.
- R8: SDRAM access followed by the other SDRAM area. The gap is 3.
- R9: SDRAM followed by static. The gap is 2.
- R10: Size code s (0..3) means 4<<s bytes. A static request is issued as 1<<s beats. Each beat has iss_size_o = 0, and iss_last_o is set only on the final beat. Between beats the gap is the cfg_same_i field for the transfer's own direction, and req_ready_o stays low until the last beat has been issued. An SDRAM request is issued once, with iss_size_o = s and iss_last_o = 1.
- R11: req_ready_o is low while an access is outstanding. After any idle stretch, even one longer than 15 cycles, every gap counts as met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_area_i | input | 2 | Target area 0..3 |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Size code, 4<<code bytes |
| cfg_same_i | input | 16 | Static gaps when the area stays the same, four 4-bit fields |
| cfg_diff_i | input | 16 | Static gaps when the area changes, four 4-bit fields |
| cfg_w2r_i | input | 4 | SDRAM write-to-read gap, same area |
| cfg_r2w_i | input | 4 | SDRAM read-to-write gap, same area |
| iss_valid_o | output | 1 | One-cycle issue strobe to the engines |
| iss_area_o | output | 2 | Area of the issued access |
| iss_wr_o | output | 1 | Direction of the issued access |
| iss_size_o | output | 2 | Size code of the issued access |
| iss_last_o | output | 1 | Final beat of the request |
| eng_done_i | input | 1 | Engine finished the issued access |

## Verification
The bench covers every cell of the gap matrix:
- the static-to-SDRAM floor, with one programmed value below it and one above it;
- the SDRAM same-direction floor of 1;
- a zero read-to-write setting, which must still give one idle cycle;
- an SDRAM area switch;
- SDRAM to static.

An error in the field index, or in which floor is applied, makes the strobe come one or more cycles early or late in exactly one of these transitions. Long bursts to static areas check the beat count, the last-beat flag and the gap between beats; a wrong beat count shows up as an extra or missing strobe. Requests held back for more than 15 idle cycles check that the counter saturates instead of wrapping, because a wrapping counter would stall the request. A second configuration mixes all-zero fields with all-ones fields, under pseudo-random traffic and varied engine latency.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  function automatic logic is_static(input logic [1:0] area);
    return (area == 2'd0) || (area == 2'd3);
  endfunction
endpackage

// File: rtl/idle_gap_sel.sv
module idle_gap_sel import idle_gap_pkg::*; #(
  parameter int CNT_W     = 4,
  parameter int FLOOR_S2D = 4,
  parameter int FLOOR_D2D = 3,
  parameter int FLOOR_D2S = 2,
  parameter int FLOOR_DD  = 1
) (
  input  logic               has_prev_i,
  input  logic [1:0]         prev_area_i,
  input  logic               prev_wr_i,
  input  logic [1:0]         next_area_i,
  input  logic               next_wr_i,
  input  logic [4*CNT_W-1:0] cfg_same_i,
  input  logic [4*CNT_W-1:0] cfg_diff_i,
  input  logic [CNT_W-1:0]   cfg_w2r_i,
  input  logic [CNT_W-1:0]   cfg_r2w_i,
  output logic [CNT_W-1:0]   gap_o
);
  localparam logic [CNT_W-1:0] F_S2D = CNT_W'(FLOOR_S2D);
  localparam logic [CNT_W-1:0] F_D2D = CNT_W'(FLOOR_D2D);
  localparam logic [CNT_W-1:0] F_D2S = CNT_W'(FLOOR_D2S);
  localparam logic [CNT_W-1:0] F_DD  = CNT_W'(FLOOR_DD);

  function automatic logic [CNT_W-1:0] umax(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [1:0]       idx;
  logic [CNT_W-1:0] same_v, diff_v;

  assign idx    = {prev_wr_i, next_wr_i};
  assign same_v = cfg_same_i[int'(idx)*CNT_W +: CNT_W];
  assign diff_v = cfg_diff_i[int'(idx)*CNT_W +: CNT_W];

  always_comb begin
    if (!has_prev_i)
      gap_o = '0;
    else if (is_static(prev_area_i) && is_static(next_area_i))
      gap_o = (prev_area_i == next_area_i) ? same_v : diff_v;
    else if (is_static(prev_area_i))
      gap_o = umax(diff_v, F_S2D);
    else if (is_static(next_area_i))
      gap_o = F_D2S;
    else if (prev_area_i != next_area_i)
      gap_o = F_D2D;
    else if (prev_wr_i == next_wr_i)
      gap_o = F_DD;
    else if (prev_wr_i)
      gap_o = umax(cfg_w2r_i, F_DD);
    else
      gap_o = umax(cfg_r2w_i, F_DD);
  end
endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o
);
  // counts idle cycles since the last completion, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (done_i)                  cnt_o <= '0;
    else if (!busy_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cnt_o == '0)); // R3
endmodule

// File: rtl/idle_gap_issuer.sv
module idle_gap_issuer import idle_gap_pkg::*; #(
  parameter int CNT_W     = 4,
  parameter int SIZE_W    = 2,
  parameter int FLOOR_S2D = 4,
  parameter int FLOOR_D2D = 3,
  parameter int FLOOR_D2S = 2,
  parameter int FLOOR_DD  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_area_i,
  input  logic               req_wr_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic [4*CNT_W-1:0] cfg_same_i,
  input  logic [4*CNT_W-1:0] cfg_diff_i,
  input  logic [CNT_W-1:0]   cfg_w2r_i,
  input  logic [CNT_W-1:0]   cfg_r2w_i,
  output logic               iss_valid_o,
  output logic [1:0]         iss_area_o,
  output logic               iss_wr_o,
  output logic [SIZE_W-1:0]  iss_size_o,
  output logic               iss_last_o,
  input  logic               eng_done_i
);
  localparam int MAX_SIZE = (1 << SIZE_W) - 1;
  localparam int BEAT_W   = (MAX_SIZE < 1) ? 1 : MAX_SIZE;

  logic              busy_q, has_prev_q, prev_wr_q;
  logic [1:0]        prev_area_q;
  logic [BEAT_W-1:0] beats_q, first_beats;
  logic              in_burst, nxt_wr, gap_ok, split;
  logic [1:0]        nxt_area;
  logic [CNT_W-1:0]  gap, idle_cnt;

  assign in_burst = (beats_q != '0);
  assign nxt_area = in_burst ? prev_area_q : req_area_i;
  assign nxt_wr   = in_burst ? prev_wr_q   : req_wr_i;

  idle_gap_sel #(
    .CNT_W(CNT_W), .FLOOR_S2D(FLOOR_S2D), .FLOOR_D2D(FLOOR_D2D),
    .FLOOR_D2S(FLOOR_D2S), .FLOOR_DD(FLOOR_DD)
  ) u_sel (
    .has_prev_i (has_prev_q),
    .prev_area_i(prev_area_q),
    .prev_wr_i  (prev_wr_q),
    .next_area_i(nxt_area),
    .next_wr_i  (nxt_wr),
    .cfg_same_i (cfg_same_i),
    .cfg_diff_i (cfg_diff_i),
    .cfg_w2r_i  (cfg_w2r_i),
    .cfg_r2w_i  (cfg_r2w_i),
    .gap_o      (gap)
  );

  idle_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_q),
    .done_i(busy_q && eng_done_i),
    .cnt_o (idle_cnt)
  );

  assign gap_ok      = (idle_cnt >= gap);
  assign split       = is_static(req_area_i);
  assign first_beats = split ? BEAT_W'((32'd1 << req_size_i) - 32'd1) : '0;

  assign req_ready_o = !busy_q && !in_burst && gap_ok;
  assign iss_valid_o = !busy_q && gap_ok && (in_burst || req_valid_i);
  assign iss_area_o  = nxt_area;
  assign iss_wr_o    = nxt_wr;
  assign iss_size_o  = (in_burst || split) ? '0 : req_size_i;
  assign iss_last_o  = in_burst ? (beats_q == BEAT_W'(1)) : (first_beats == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      has_prev_q  <= 1'b0;
      prev_area_q <= '0;
      prev_wr_q   <= 1'b0;
      beats_q     <= '0;
    end else if (iss_valid_o) begin
      busy_q      <= 1'b1;
      has_prev_q  <= 1'b1;
      prev_area_q <= nxt_area;
      prev_wr_q   <= nxt_wr;
      beats_q     <= in_burst ? beats_q - 1'b1 : first_beats;
    end else if (busy_q && eng_done_i) begin
      busy_q      <= 1'b0;
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |=> !iss_valid_o); // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !req_ready_o); // R11
  AST_FIRST_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!has_prev_q && !busy_q && req_valid_i) |-> iss_valid_o); // R1
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst |-> !req_ready_o); // R10
  AST_BEAT_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && is_static(iss_area_o)) |-> (iss_size_o == '0)); // R10
  AST_S2D_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && has_prev_q && is_static(prev_area_q) && !is_static(iss_area_o))
      |-> (int'(idle_cnt) >= FLOOR_S2D)); // R5
  AST_D2S_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && has_prev_q && !is_static(prev_area_q) && is_static(iss_area_o))
      |-> (int'(idle_cnt) >= FLOOR_D2S)); // R9
endmodule

// File: tb/sim_idle_gap_issuer.sv
`timescale 1ns/1ps
module sim_idle_gap_issuer;
  typedef struct packed {
    logic [1:0] area;
    logic       wr;
    logic [1:0] size;
    logic [7:0] delay;
  } req_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_area_i = '0;
  logic        req_wr_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [15:0] cfg_same_i = '0;
  logic [15:0] cfg_diff_i = '0;
  logic [3:0]  cfg_w2r_i = '0;
  logic [3:0]  cfg_r2w_i = '0;
  logic        eng_done_i = 1'b0;
  logic        req_ready_o, iss_valid_o, iss_wr_o, iss_last_o;
  logic [1:0]  iss_area_o, iss_size_o;

  always #2.5 clk_i = ~clk_i;

  idle_gap_issuer u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  req_t q[$];
  int delay_left = 0;
  int eng_left = 0, n_iss = 0;
  // reference state
  int m_busy = 0, m_has = 0, m_pa = 0, m_pw = 0, m_beats = 0, m_idle = 0;

  function automatic int fld(input logic [15:0] v, input int pw, input int nw);
    return int'((v >> (4 * (pw * 2 + nw))) & 16'hF);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic want_gap(input int pa, input int pw, input int na, input int nw,
                          output int g, output string tag);
    bit ps, ns;
    ps = (pa == 0 || pa == 3);
    ns = (na == 0 || na == 3);
    case ({ps, ns})
      2'b11: begin
        g = (pa == na) ? fld(cfg_same_i, pw, nw) : fld(cfg_diff_i, pw, nw);
        tag = "R4";
      end
      2'b10: begin g = mx(fld(cfg_diff_i, pw, nw), 4); tag = "R5"; end
      2'b01: begin g = 2; tag = "R9"; end
      default: begin
        if (pa != na)        begin g = 3; tag = "R8"; end
        else if (pw == nw)   begin g = 1; tag = "R6"; end
        else if (pw == 1)    begin g = mx(int'(cfg_w2r_i), 1); tag = "R7"; end
        else                 begin g = mx(int'(cfg_r2w_i), 1); tag = "R7"; end
      end
    endcase
  endtask

  task automatic add(input int a, input int w, input int s, input int d);
    req_t r;
    r.area = 2'(a); r.wr = 1'(w); r.size = 2'(s); r.delay = 8'(d);
    if (q.size() == 0) delay_left = d;
    q.push_back(r);
  endtask

  task automatic step();
    bit    e_rdy, e_iss, e_wr, e_last, burst, done_now, mism;
    int    e_area, e_size, need, na, nw;
    string tag, rtag;
    @(negedge clk_i);
    cyc++;
    done_now = (eng_left == 1);
    if (eng_left > 0) eng_left--;
    eng_done_i = done_now;
    req_valid_i = (q.size() > 0) && (delay_left == 0);
    if (q.size() > 0) begin
      req_area_i = q[0].area; req_wr_i = q[0].wr; req_size_i = q[0].size;
    end
    #1;
    e_rdy = 0; e_iss = 0; e_area = 0; e_wr = 0; e_size = 0; e_last = 0;
    tag = "R11"; rtag = "R11";
    burst = (m_beats > 0);
    if (m_busy == 0) begin
      na = burst ? m_pa : int'(req_area_i);
      nw = burst ? m_pw : int'(req_wr_i);
      if (m_has == 0) begin need = 0; tag = "R1"; end
      else want_gap(m_pa, m_pw, na, nw, need, tag);
      if (burst) tag = "R10";
      if (m_idle >= need) begin
        e_rdy = !burst;
        e_iss = burst || req_valid_i;
      end
      if (!burst) rtag = tag;
      e_area = na; e_wr = nw[0];
      if (burst) begin
        e_size = 0; e_last = (m_beats == 1);
      end else if (na == 0 || na == 3) begin
        e_size = 0; e_last = (req_size_i == 0);
      end else begin
        e_size = int'(req_size_i); e_last = 1;
      end
    end
    checks++;
    mism = (req_ready_o !== e_rdy) || (iss_valid_o !== e_iss);
    if (e_iss) mism = mism || (int'(iss_area_o) != e_area) || (iss_wr_o !== e_wr)
                    || (int'(iss_size_o) != e_size) || (iss_last_o !== e_last);
    if (mism) begin
      fails++;
      $display("FAIL %s cyc=%0d ready=%b/%b iss=%b/%b area=%0d/%0d wr=%b/%b size=%0d/%0d last=%b/%b",
               (req_ready_o !== e_rdy) ? rtag : ((iss_valid_o !== e_iss) ? tag :
               ((int'(iss_area_o) != e_area || iss_wr_o !== e_wr) ? "R2" : "R10")),
               cyc, req_ready_o, e_rdy, iss_valid_o, e_iss, iss_area_o, e_area,
               iss_wr_o, e_wr, iss_size_o, e_size, iss_last_o, e_last);
    end
    // advance reference
    if (e_iss) begin
      m_busy = 1; m_has = 1; m_pa = e_area; m_pw = int'(e_wr);
      if (burst) m_beats--;
      else begin
        m_beats = (e_area == 0 || e_area == 3) ? ((1 << req_size_i) - 1) : 0;
        void'(q.pop_front());
        if (q.size() > 0) delay_left = int'(q[0].delay);
      end
      n_iss++;
      eng_left = 1 + (n_iss % 3);
    end else if (m_busy == 0) begin
      m_idle++;
    end
    if (m_busy == 1 && done_now) begin m_busy = 0; m_idle = 0; end
    if (!e_iss && q.size() > 0 && delay_left > 0) delay_left--;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q.size() > 0 || m_busy == 1 || m_beats > 0 || eng_left > 0) && guard < 60000) begin
      step();
      guard++;
    end
    if (guard >= 60000) begin
      checks++; fails++;
      $display("FAIL R3 watchdog expired cyc=%0d pending=%0d/0", cyc, q.size());
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    cfg_same_i = 16'h5273; cfg_diff_i = 16'h6184; cfg_w2r_i = 4'd5; cfg_r2w_i = 4'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    checks++;
    if (req_ready_o !== 1'b1 || iss_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset ready=%b/1 iss=%b/0", req_ready_o, iss_valid_o);
    end
    m_idle = 1;
    // directed walk over the gap matrix
    add(0,0,0,0); add(0,0,0,0); add(0,1,0,0); add(3,1,0,0); add(3,0,0,0);
    add(1,0,0,0); add(1,0,0,0); add(1,1,0,0); add(1,0,0,0); add(2,0,0,0);
    add(0,1,2,0); add(3,0,3,0); add(2,1,3,0); add(2,1,1,20); add(0,0,0,20);
    add(1,1,0,0); add(0,1,1,2); add(2,0,0,0); add(2,1,0,0); add(2,0,0,0);
    drain();
    // second configuration with extreme fields, pseudo-random traffic
    cfg_same_i = 16'h0F0A; cfg_diff_i = 16'hF00C; cfg_w2r_i = 4'd0; cfg_r2w_i = 4'd9;
    lfsr = 16'hACE1;
    for (int i = 0; i < 160; i++) begin
      for (int k = 0; k < 8; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      add(int'(lfsr[1:0]), int'(lfsr[2]), int'(lfsr[4:3]),
          (lfsr[11:9] == 3'd7) ? 18 : int'(lfsr[7:5]));
    end
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule